// File: doc/BRIEF.md
# Multi-Chip Hit Stream Merger

This block sits between a set of front-end sensor chips and a fiber serializer. Each chip drives one or more serial lines, and each line carries 20-bit words sent most significant bit first, one bit per clock. For each line the block finds the word boundary by hunting for a fixed sync pattern at any bit offset. It confirms the lock over several words and watches for the pattern drifting to another offset. Sync words and idle words are dropped. Hit words are tagged with the number of the chip that sent them.

Each line has a small FIFO. A round-robin merger drains the FIFOs into one registered 22-bit output with a valid/ready handshake, at one word per cycle. A lock flag and a sticky overflow flag for each line are visible at the ports. Line `l` belongs to chip `l / LINES_PER_CHIP`.

Top module: `hsm_merger`

## Requirements
- R1: While reset is held and just after it is released, `out_valid`, `lane_locked` and `lane_ovf` are all 0.
- R2: A line becomes locked after its serial stream carries the sync pattern 20'hB1E6D (MSB first) on three consecutive words at the same bit offset. The first of these words may start at any bit offset.
- R3: If a line sees only two aligned sync words and then a word that is not the sync pattern, it stays unlocked and hunts for the pattern again.
- R4: On a locked line, words whose type bits [19:18] are 00 (idle), 10 (sync) or 11 (reserved) produce no output word.
- R5: Hit words (type bits [19:18] = 01) that arrive on a line that is not locked are dropped.
- R6: A hit word carries adc in bits [17:15], strip in [14:8] and bco in [7:2], and bits [1:0] are spare. The block outputs it as {chip[5:0], adc[2:0], strip[6:0], bco[5:0]}, where chip = line index / LINES_PER_CHIP.
- R7: A locked line drops its lock after three consecutive sync patterns appear at a bit offset other than the locked word boundary. An aligned sync word between two such patterns restarts the count.
- R8: When several lines have words pending, they are served in cyclic ascending order, starting after the line served last. The block outputs at most one word per cycle.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold their values.
- R10: A hit that arrives on a line whose FIFO is full is dropped and sets that line's bit in `lane_ovf`. The bit stays set until reset. The output register plus a FIFO of FIFO_DEPTH words is the buffering for each line.
- R11: Words from one line leave in the order they arrived, and no accepted hit is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one serial bit per line per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ser_in | input | N_LANES | One serial bit per line, MSB of each word first |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 22 | {chip, adc, strip, bco} |
| lane_locked | output | N_LANES | Word-boundary lock flag for each line |
| lane_ovf | output | N_LANES | Sticky FIFO overflow flag for each line |

## Verification
The bench trains one line with only two sync words and then sends it a hit. A design that counts too eagerly would lock and forward that hit. It locks another line seven bits off the others. It then shifts that line's phase with single misaligned sync words, placing an aligned sync between them, which catches a loss counter that never clears or one that drops the lock too early. Reserved-type and idle words with nonzero payload are sent on a locked line to show that only the hit type is forwarded. Under held backpressure, the bench checks the order in which three lines are served, the stability of the held word, and the exact point at which a line overflows. A merger that skips a line, repeats one, or buffers one word too many or too few shows up in the output sequence or in the flags.

// File: rtl/hsm_pkg.sv
package hsm_pkg;
  localparam int WORD_W    = 20;
  localparam int PAYLOAD_W = 16;
  localparam int CHIP_ID_W = 6;
  localparam int OUT_W     = CHIP_ID_W + PAYLOAD_W;

  typedef enum logic [1:0] {
    TY_IDLE = 2'b00,
    TY_HIT  = 2'b01,
    TY_SYNC = 2'b10,
    TY_RSV  = 2'b11
  } word_type_e;
endpackage

// File: rtl/hsm_lane_rx.sv
module hsm_lane_rx import hsm_pkg::*; #(
  parameter logic [WORD_W-1:0] SYNC_PAT = 20'hB1E6D,
  parameter int LOCK_CNT = 3,
  parameter int LOSS_CNT = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_bit,
  output logic                 hit_vld,
  output logic [PAYLOAD_W-1:0] hit_payload,
  output logic                 locked
);
  localparam int PW = $clog2(WORD_W);
  localparam int GW = $clog2(LOCK_CNT + 1);
  localparam int MW = $clog2(LOSS_CNT + 1);

  typedef enum logic [1:0] {ST_HUNT, ST_CHECK, ST_LOCK} rx_state_e;

  rx_state_e            st_q, st_d;
  logic [WORD_W-1:0]    sr_q, sr_d;
  logic [PW-1:0]        pos_q, pos_d;
  logic [GW-1:0]        good_q, good_d;
  logic [MW-1:0]        miss_q, miss_d;
  logic                 vld_q, vld_d;
  logic [PAYLOAD_W-1:0] pay_q;
  logic                 is_sync, at_bnd;

  always_comb begin
    sr_d    = {sr_q[WORD_W-2:0], ser_bit};
    is_sync = (sr_d == SYNC_PAT);
    at_bnd  = (pos_q == PW'(WORD_W - 1));
    pos_d   = at_bnd ? '0 : pos_q + 1'b1;
    st_d    = st_q;
    good_d  = good_q;
    miss_d  = miss_q;
    vld_d   = 1'b0;
    unique case (st_q)
      ST_HUNT: begin
        if (is_sync) begin
          pos_d  = '0;
          good_d = GW'(1);
          st_d   = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (at_bnd) begin
          if (!is_sync) begin
            st_d = ST_HUNT;
          end else if (good_q == GW'(LOCK_CNT - 1)) begin
            st_d   = ST_LOCK;
            miss_d = '0;
          end else begin
            good_d = good_q + 1'b1;
          end
        end
      end
      ST_LOCK: begin
        if (at_bnd) begin
          if (is_sync) begin
            miss_d = '0;
          end else if (sr_d[WORD_W-1 -: 2] == 2'(TY_HIT)) begin
            vld_d = 1'b1;
          end
        end else if (is_sync) begin
          if (miss_q == MW'(LOSS_CNT - 1)) st_d = ST_HUNT;
          else miss_d = miss_q + 1'b1;
        end
      end
      default: st_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      sr_q   <= '0;
      pos_q  <= '0;
      good_q <= '0;
      miss_q <= '0;
      vld_q  <= 1'b0;
      pay_q  <= '0;
    end else begin
      st_q   <= st_d;
      sr_q   <= sr_d;
      pos_q  <= pos_d;
      good_q <= good_d;
      miss_q <= miss_d;
      vld_q  <= vld_d;
      if (vld_d) pay_q <= sr_d[WORD_W-3:2];
    end
  end

  assign hit_vld     = vld_q;
  assign hit_payload = pay_q;
  assign locked      = (st_q == ST_LOCK);
endmodule

// File: rtl/hsm_fifo.sv
module hsm_fifo #(
  parameter int W     = 22,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp_q, rp_q, wp_d, rp_d;

  assign empty = (wp_q == rp_q);
  assign full  = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign dout  = mem[rp_q[AW-1:0]];

  always_comb begin
    wp_d = push ? wp_q + 1'b1 : wp_q;
    rp_d = pop  ? rp_q + 1'b1 : rp_q;
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q[AW-1:0]] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
    end
  end
endmodule

// File: rtl/hsm_rr_arb.sv
module hsm_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         adv,
  output logic [N-1:0] gnt,
  output logic         any
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] last_q, last_d;

  always_comb begin
    gnt    = '0;
    last_d = last_q;
    for (int k = 1; k <= N; k++) begin
      if (gnt == '0 && req[(int'(last_q) + k) % N]) begin
        gnt[(int'(last_q) + k) % N] = 1'b1;
        last_d = IW'((int'(last_q) + k) % N);
      end
    end
  end

  assign any = |req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IW'(N - 1);
    else if (adv && any) last_q <= last_d;
  end
endmodule

// File: rtl/hsm_merger.sv
module hsm_merger import hsm_pkg::*; #(
  parameter int N_CHIPS        = 2,
  parameter int LINES_PER_CHIP = 2,
  parameter int FIFO_DEPTH     = 4,
  parameter logic [WORD_W-1:0] SYNC_PAT = 20'hB1E6D,
  parameter int LOCK_CNT       = 3,
  parameter int LOSS_CNT       = 3,
  localparam int N_LANES       = N_CHIPS * LINES_PER_CHIP
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LANES-1:0] ser_in,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [OUT_W-1:0]   out_data,
  output logic [N_LANES-1:0] lane_locked,
  output logic [N_LANES-1:0] lane_ovf
);
  logic [1:0]           rst_sync_q;
  logic                 rst_n_int;
  logic [N_LANES-1:0]   hit_vld, push_vec, pop_vec, fifo_full, fifo_empty, gnt;
  logic [PAYLOAD_W-1:0] hit_pay   [N_LANES];
  logic [OUT_W-1:0]     fifo_dout [N_LANES];
  logic [N_LANES-1:0]   ovf_q, ovf_d;
  logic                 any, load, take;
  logic                 vld_q, vld_d;
  logic [OUT_W-1:0]     data_q, sel_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    localparam logic [CHIP_ID_W-1:0] CHIP = CHIP_ID_W'(l / LINES_PER_CHIP);

    hsm_lane_rx #(
      .SYNC_PAT (SYNC_PAT),
      .LOCK_CNT (LOCK_CNT),
      .LOSS_CNT (LOSS_CNT)
    ) u_rx (
      .clk         (clk),
      .rst_n       (rst_n_int),
      .ser_bit     (ser_in[l]),
      .hit_vld     (hit_vld[l]),
      .hit_payload (hit_pay[l]),
      .locked      (lane_locked[l])
    );

    assign push_vec[l] = hit_vld[l] & ~fifo_full[l];

    hsm_fifo #(
      .W     (OUT_W),
      .DEPTH (FIFO_DEPTH)
    ) u_fifo (
      .clk   (clk),
      .rst_n (rst_n_int),
      .push  (push_vec[l]),
      .din   ({CHIP, hit_pay[l]}),
      .pop   (pop_vec[l]),
      .dout  (fifo_dout[l]),
      .full  (fifo_full[l]),
      .empty (fifo_empty[l])
    );
  end

  hsm_rr_arb #(.N(N_LANES)) u_arb (
    .clk   (clk),
    .rst_n (rst_n_int),
    .req   (~fifo_empty),
    .adv   (load),
    .gnt   (gnt),
    .any   (any)
  );

  always_comb begin
    sel_data = '0;
    for (int l = 0; l < N_LANES; l++) begin
      if (gnt[l]) sel_data = sel_data | fifo_dout[l];
    end
    take    = ~vld_q | out_ready;
    load    = take & any;
    pop_vec = gnt & {N_LANES{load}};
    vld_d   = take ? any : vld_q;
    ovf_d   = ovf_q | (hit_vld & fifo_full);
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      vld_q  <= 1'b0;
      data_q <= '0;
      ovf_q  <= '0;
    end else begin
      vld_q <= vld_d;
      ovf_q <= ovf_d;
      if (load) data_q <= sel_data;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = data_q;
  assign lane_ovf  = ovf_q;
endmodule

// File: rtl/hsm_merger_chk.sv
module hsm_merger_chk #(
  parameter int N_LANES = 4,
  parameter int N_CHIPS = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               out_valid,
  input logic               out_ready,
  input logic [21:0]        out_data,
  input logic [N_LANES-1:0] lane_locked,
  input logic [N_LANES-1:0] lane_ovf,
  input logic [N_LANES-1:0] push_vec,
  input logic [N_LANES-1:0] pop_vec,
  input logic [N_LANES-1:0] fifo_empty
);
  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_ovf != '0) |=> ((lane_ovf & $past(lane_ovf)) == $past(lane_ovf))); // R10

  AST_NO_PUSH_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((push_vec & ~lane_locked) == '0)); // R5

  AST_SINGLE_POP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pop_vec)); // R8

  AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ((pop_vec & fifo_empty) == '0)); // R11

  AST_CHIP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_data[21:16]) < N_CHIPS)); // R6
endmodule

bind hsm_merger hsm_merger_chk #(
  .N_LANES (N_LANES),
  .N_CHIPS (N_CHIPS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .lane_locked (lane_locked),
  .lane_ovf    (lane_ovf),
  .push_vec    (push_vec),
  .pop_vec     (pop_vec),
  .fifo_empty  (fifo_empty)
);

// File: tb/sim_hsm_merger.sv
module sim_hsm_merger;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 4;
  localparam logic [19:0] SYNC = 20'hB1E6D;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NL-1:0] ser_in;
  logic          out_valid, out_ready;
  logic [21:0]   out_data;
  logic [NL-1:0] lane_locked, lane_ovf;

  hsm_merger u0 (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .lane_locked(lane_locked), .lane_ovf(lane_ovf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;
  int out_count = 0;
  bit rec_en = 1'b0;
  int rec_lane[$];
  logic [1:0]  bq[NL][$];
  int          real_cnt[NL];
  logic [21:0] exp_q[NL][$];

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [19:0] hitw(int adc, int strip, int bco);
    return {2'b01, 3'(adc), 7'(strip), 6'(bco), 2'b11};
  endfunction

  task automatic push_bits(int l, logic [19:0] w, int n);
    for (int b = n - 1; b >= 0; b--) bq[l].push_back({1'b1, w[b]});
    real_cnt[l] += n;
  endtask

  task automatic push_word(int l, logic [19:0] w, bit expect_out);
    push_bits(l, w, 20);
    if (expect_out) exp_q[l].push_back({6'(l / 2), w[17:2]});
  endtask

  task automatic misaligned_sync(int l);
    push_bits(l, 20'h0, 7);
    push_word(l, SYNC, 1'b0);
    push_bits(l, 20'h0, 13);
  endtask

  task automatic drain();
    bit busy;
    do begin
      @(negedge clk);
      busy = 1'b0;
      for (int l = 0; l < NL; l++) if (real_cnt[l] > 0) busy = 1'b1;
    end while (busy);
    repeat (30) @(negedge clk);
  endtask

  task automatic set_ready(logic v);
    @(posedge clk);
    #1 out_ready = v;
  endtask

  // serial driver: idle words fill empty lanes, keeping word phase
  initial begin
    ser_in = '0;
    for (int l = 0; l < NL; l++) real_cnt[l] = 0;
    forever begin
      @(negedge clk);
      for (int l = 0; l < NL; l++) begin
        logic [1:0] e;
        if (bq[l].size() == 0)
          for (int b = 0; b < 20; b++) bq[l].push_back(2'b00);
        e = bq[l].pop_front();
        ser_in[l] = e[0];
        if (e[1]) real_cnt[l]--;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    bit          hold_prev;
    logic [21:0] data_prev;
    hold_prev = 1'b0;
    data_prev = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (hold_prev)
          chk(out_valid && out_data == data_prev, "R9", "held word changed",
              {9'd0, out_valid, out_data}, {10'd1, data_prev});
        hold_prev = out_valid && !out_ready;
        data_prev = out_data;
        if (out_valid && out_ready) begin
          int  c;
          bit  found;
          out_count++;
          c = int'(out_data[21:16]);
          found = 1'b0;
          for (int l = 2 * c; l < 2 * c + 2 && l < NL; l++)
            if (!found && exp_q[l].size() > 0 && exp_q[l][0] == out_data) begin
              void'(exp_q[l].pop_front());
              found = 1'b1;
            end
          chk(found, "R5/R6/R11", "output word not expected at head of its line",
              {10'd0, out_data}, 32'h0);
          if (rec_en) rec_lane.push_back(int'(out_data[12:10]));
        end
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  function automatic int rr_next(int p);
    return (p == 0) ? 1 : (p == 1) ? 3 : 0;
  endfunction

  initial begin
    int c0;
    rst_n = 1'b0;
    out_ready = 1'b1;
    repeat (5) @(negedge clk);
    chk(out_valid == 1'b0 && lane_locked == '0 && lane_ovf == '0, "R1", "state in reset",
        {out_valid, lane_locked, lane_ovf}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0 && lane_locked == '0 && lane_ovf == '0, "R1", "state after reset",
        {out_valid, lane_locked, lane_ovf}, 32'h0);

    // R3: two syncs then a hit, never locks; R5: that hit is dropped
    push_word(0, SYNC, 1'b0);
    push_word(0, SYNC, 1'b0);
    push_word(0, hitw(5, 9, 33), 1'b0);
    drain();
    chk(lane_locked == '0, "R3", "lock after only two syncs", 32'(lane_locked), 32'h0);
    chk(out_count == 0, "R5", "hit on unlocked line forwarded", out_count, 0);

    // R2: lock on all lines, line 2 offset by seven bits
    for (int l = 0; l < NL; l++) begin
      if (l == 2) push_bits(2, 20'h0, 7);
      for (int k = 0; k < 3; k++) push_word(l, SYNC, 1'b0);
    end
    drain();
    chk(lane_locked == 4'hF, "R2", "lock after three aligned syncs", 32'(lane_locked), 32'hF);

    // R6: one hit on each line, chip id from line index
    c0 = out_count;
    for (int l = 0; l < NL; l++) push_word(l, hitw(l + 1, 100 + l, 40 + l), 1'b1);
    drain();
    chk(out_count == c0 + 4, "R6", "hit count", out_count - c0, 4);

    // R4: idle, sync, reserved and idle-with-payload words on a locked line
    c0 = out_count;
    push_word(1, 20'h00000, 1'b0);
    push_word(1, SYNC, 1'b0);
    push_word(1, 20'hC1234, 1'b0);
    push_word(1, 20'h0ABCD, 1'b0);
    drain();
    chk(out_count == c0, "R4", "non-hit words forwarded", out_count - c0, 0);
    chk(lane_locked[1] == 1'b1, "R4", "lock kept on line 1", 32'(lane_locked[1]), 1);

    // R8: three lines queued under backpressure, then released
    set_ready(1'b0);
    foreach (rec_lane[i]) rec_lane.delete(i);
    for (int k = 0; k < 2; k++) begin
      push_word(0, hitw(1, 0 * 16 + k, k), 1'b1);
      push_word(1, hitw(2, 1 * 16 + k, k), 1'b1);
      push_word(3, hitw(3, 3 * 16 + k, k), 1'b1);
    end
    drain();
    rec_en = 1'b1;
    set_ready(1'b1);
    repeat (20) @(negedge clk);
    rec_en = 1'b0;
    chk(rec_lane.size() == 6, "R8", "served word count", rec_lane.size(), 6);
    for (int i = 1; i < rec_lane.size(); i++)
      chk(rec_lane[i] == rr_next(rec_lane[i-1]), "R8", "round-robin order",
          rec_lane[i], rr_next(rec_lane[i-1]));

    // R10: overflow of line 3 while output is stalled
    set_ready(1'b0);
    for (int k = 0; k < 7; k++) push_word(3, hitw(4, 3 * 16 + 8 + k, k), k < 5);
    drain();
    chk(lane_ovf == 4'b1000, "R10", "overflow flag set", 32'(lane_ovf), 32'h8);
    set_ready(1'b1);
    drain();
    chk(lane_ovf == 4'b1000, "R10", "overflow flag sticky", 32'(lane_ovf), 32'h8);

    // R7: misaligned syncs, count restarted by an aligned sync
    misaligned_sync(2);
    misaligned_sync(2);
    push_word(2, SYNC, 1'b0);
    misaligned_sync(2);
    misaligned_sync(2);
    drain();
    chk(lane_locked[2] == 1'b1, "R7", "lock held after restarted count",
        32'(lane_locked[2]), 1);
    misaligned_sync(2);
    drain();
    chk(lane_locked[2] == 1'b0, "R7", "lock lost after three misaligned",
        32'(lane_locked[2]), 0);
    c0 = out_count;
    push_word(2, hitw(6, 77, 12), 1'b0);
    drain();
    chk(out_count == c0, "R5", "hit after lock loss forwarded", out_count - c0, 0);

    // R11: every accepted hit came out
    for (int l = 0; l < NL; l++)
      chk(exp_q[l].size() == 0, "R11", "words left unmatched", exp_q[l].size(), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule